// File: doc/BRIEF.md
# Rotating Register Rename Unit

This unit turns a logical register number into a physical register number for the rotating part of a register file. Each of three register classes has its own rename base. Inside a class's rotating window, the physical index is the logical offset plus that base, reduced modulo the window size and placed back at the window start. Any number outside the window maps to itself.

A single rotate strobe steps all three bases down by one, each modulo its own window size. After a rotation, the value that was read at logical n is read at logical n+1, and the top register of a window becomes its bottom register. A clear strobe returns every base to zero.

When a rotation is accepted, the unit also asserts a strobe that names the physical predicate register currently seen as the top rotating predicate. The predicate file clears that register before the rotation, so it becomes the fresh bottom predicate afterwards.

Top module: `rot_rename`

## Requirements
- R1: After reset all three bases are zero, so every logical number maps to itself in every class.
- R2: Class code 0 is general, 1 is predicate, 2 is floating and 3 is unrotated. A number below the window start maps to itself. The same holds for a predicate number above 63, a general number at or above 32 plus the general size, and any number under class 3.
- R3: A number l inside a window [lo, lo+size) maps to lo + ((l - lo + base) mod size). The general window starts at 32 and spans the general size. The predicate window is 16..63 and the floating window is 16..127.
- R4: An accepted rotation steps every base down by one modulo its window size. The register seen at logical n before the rotation is seen at n+1 after it, and the one seen at the top of a window is seen at its bottom.
- R5: A clear strobe sets all three bases to zero on the next clock edge.
- R6: When clear and rotate are asserted in the same cycle, clear wins: the bases become zero and no rotation is signalled.
- R7: The general size is a multiple of 8 no larger than 96. A size of zero maps every general number to itself, and rotations then leave general mapping unchanged.
- R8: During a cycle with an accepted rotation, `pclr_o` is high. In that cycle `pclr_idx_o` is the physical register that logical predicate 63 maps to. `pclr_o` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rot_i | input | 1 | Rotate strobe from loop-closing branch |
| clr_i | input | 1 | Clear all rename bases |
| gsize_i | input | 7 | Size of the general rotating window |
| cls_i | input | 2 | Register class of the lookup |
| lreg_i | input | 7 | Logical register number |
| preg_o | output | 7 | Physical register number |
| pclr_o | output | 1 | Clear request for the top rotating predicate |
| pclr_idx_o | output | 7 | Physical index of that predicate |

## Verification
The assertions take the general size to be a multiple of 8 no larger than 96. They also take it to change only while the general base is zero, so that the general base always lies below the size. The stimulus follows both rules: it pulses clear before every change of size and picks sizes of 16, 96 and 0. Between rotations it sweeps every class against every logical number. Those sweeps carry the bases through full wraps of all three windows.

// File: rtl/rot_rename.sv
module rot_rename #(
  parameter int RW   = 7,
  parameter int GLO  = 32,
  parameter int GMAX = 96,
  parameter int PLO  = 16,
  parameter int PHI  = 63,
  parameter int FLO  = 16,
  parameter int FHI  = 127
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rot_i,
  input  logic          clr_i,
  input  logic [RW-1:0] gsize_i,
  input  logic [1:0]    cls_i,
  input  logic [RW-1:0] lreg_i,
  output logic [RW-1:0] preg_o,
  output logic          pclr_o,
  output logic [RW-1:0] pclr_idx_o
);
  localparam int PSZ = PHI - PLO + 1;
  localparam int FSZ = FHI - FLO + 1;

  logic [RW-1:0] bg, bp, bf;
  logic          step;

  function automatic logic [RW-1:0] remap(input logic [RW-1:0] l, input int lo,
                                          input int sz, input logic [RW-1:0] b);
    int s;
    if (sz == 0 || int'(l) < lo || int'(l) >= lo + sz) return l;
    s = int'(l) - lo + int'(b);
    if (s >= sz) s = s - sz;
    return RW'(lo + s);
  endfunction

  always_comb begin
    case (cls_i)
      2'd0:    preg_o = remap(lreg_i, GLO, int'(gsize_i), bg);
      2'd1:    preg_o = remap(lreg_i, PLO, PSZ, bp);
      2'd2:    preg_o = remap(lreg_i, FLO, FSZ, bf);
      default: preg_o = lreg_i;
    endcase
  end

  assign step       = rot_i & ~clr_i;
  assign pclr_o     = step;
  assign pclr_idx_o = remap(RW'(PHI), PLO, PSZ, bp);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      bg <= '0;
      bp <= '0;
      bf <= '0;
    end else if (rot_i) begin
      if (gsize_i == '0)   bg <= '0;
      else if (bg == '0)   bg <= gsize_i - 1'b1;
      else                 bg <= bg - 1'b1;
      bp <= (bp == '0) ? RW'(PSZ - 1) : bp - 1'b1;
      bf <= (bf == '0) ? RW'(FSZ - 1) : bf - 1'b1;
    end
  end

  logic [RW-1:0] p16_now;
  assign p16_now = remap(RW'(PLO), PLO, PSZ, bp);

  a_r4_top_to_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_i && !clr_i) |=> p16_now == $past(pclr_idx_o));

  a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (bg == '0 && bp == '0 && bf == '0));

  a_r2_low_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (lreg_i < RW'(PLO)) |-> preg_o == lreg_i);

  a_r3_float_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == 2'd2 && lreg_i >= RW'(FLO)) |-> preg_o >= RW'(FLO));

  a_r7_zero_size_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == 2'd0 && gsize_i == '0) |-> preg_o == lreg_i);

  a_r7_gsize_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (gsize_i[2:0] == 3'd0 && int'(gsize_i) <= GMAX && (gsize_i == '0 || bg < gsize_i)));
endmodule

// File: tb/rot_rename_bench.sv
`timescale 1ns/1ps
module rot_rename_bench;
  logic       clk = 1'b0;
  logic       rst_n, rot_i, clr_i;
  logic [6:0] gsize_i, lreg_i, preg_o, pclr_idx_o;
  logic [1:0] cls_i;
  logic       pclr_o;

  int total = 0, bad = 0;
  int mbg = 0, mbp = 0, mbf = 0, gs = 16;
  bit done = 0;

  rot_rename u_rot_rename (
    .clk(clk), .rst_n(rst_n), .rot_i(rot_i), .clr_i(clr_i), .gsize_i(gsize_i),
    .cls_i(cls_i), .lreg_i(lreg_i), .preg_o(preg_o), .pclr_o(pclr_o),
    .pclr_idx_o(pclr_idx_o));

  always #10 clk = ~clk;

  function automatic int expect_map(int c, int l);
    int lo, sz, b;
    case (c)
      0: begin lo = 32; sz = gs;  b = mbg; end
      1: begin lo = 16; sz = 48;  b = mbp; end
      2: begin lo = 16; sz = 112; b = mbf; end
      default: begin lo = 0; sz = 0; b = 0; end
    endcase
    if (sz == 0 || l < lo || l >= lo + sz) return l;
    return lo + (l - lo + b) % sz;
  endfunction

  function automatic bit in_win(int c, int l);
    return expect_map(c, l) != l || (c == 1 && l >= 16 && l < 64) ||
           (c == 2 && l >= 16) || (c == 0 && gs != 0 && l >= 32 && l < 32 + gs);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sweep(string phase);
    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 128; l++) begin
        string tag;
        cls_i  = 2'(c);
        lreg_i = 7'(l);
        #1;
        if (phase != "") tag = phase;
        else if (c == 0 && gs == 0) tag = "R7";
        else if (in_win(c, l)) tag = "R3 R4";
        else tag = "R2";
        chk($sformatf("%s cls=%0d l=%0d", tag, c, l), int'(preg_o), expect_map(c, l));
      end
    end
    chk("R8 idle", int'(pclr_o), 0);
  endtask

  task automatic rotate_once();
    int top_f;
    @(negedge clk);
    cls_i = 2'd2; lreg_i = 7'd127;
    #1 top_f = int'(preg_o);
    rot_i = 1'b1;
    #1;
    chk("R8 strobe", int'(pclr_o), 1);
    chk("R8 index", int'(pclr_idx_o), expect_map(1, 63));
    @(posedge clk);
    mbg = (gs == 0) ? 0 : (mbg + gs - 1) % gs;
    mbp = (mbp + 47) % 48;
    mbf = (mbf + 111) % 112;
    #1 rot_i = 1'b0;
    cls_i = 2'd2; lreg_i = 7'd16;
    #1 chk("R4 top wraps to bottom", int'(preg_o), top_f);
  endtask

  task automatic clear_base(bit with_rot, string tag);
    @(negedge clk);
    clr_i = 1'b1; rot_i = with_rot;
    #1 chk({tag, " no rotate signal"}, int'(pclr_o), 0);
    @(posedge clk);
    mbg = 0; mbp = 0; mbf = 0;
    #1 clr_i = 1'b0; rot_i = 1'b0;
    sweep(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rot_i = 1'b0; clr_i = 1'b0;
    gsize_i = 7'd16; gs = 16; cls_i = 2'd0; lreg_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");

    for (int i = 0; i < 20; i++) begin
      rotate_once();
      sweep("");
    end
    clear_base(1'b0, "R5");

    for (int i = 0; i < 3; i++) rotate_once();
    sweep("");
    clear_base(1'b1, "R6");

    gsize_i = 7'd96; gs = 96;
    for (int i = 0; i < 115; i++) begin
      rotate_once();
      sweep("");
    end
    clear_base(1'b0, "R5");

    gsize_i = 7'd0; gs = 0;
    for (int i = 0; i < 5; i++) begin
      rotate_once();
      sweep("");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule